// File: doc/BRIEF.md
# Programmable Galois-Field CRC and Random Generator

This block holds a software-written feedback polynomial and a 32-bit shift state. With the CRC function selected, it folds each accepted 32-bit data word into the state. All 32 serial Galois steps of a word complete in a single clock, so software can read or reload the state between any two words. A bit-order select sets both the order in which data bits are taken and the direction in which the state shifts. The polynomial and the state are therefore read in the form that matches that direction.

The same state can instead run as a pseudo-random generator. It delivers a byte per clock, or a bit per clock when an external entropy bit is folded into the feedback. The entropy bit can also be passed straight through, one bit per clock, with the generator off. In that case the CRC path stays free to process words in the same cycle. A one-cycle done pulse marks the end of a CRC batch.

Top module: `gf_crc_prng_engine`

## Requirements
- R1: While rst_n is low, poly_q, state_q, rnd_data, rnd_valid, rnd_single and gf_done are all zero.
- R2: poly_wr and state_wr load their registers at the clock edge, and the new values show on poly_q and state_q after that edge. A state_wr wins over any CRC word or generator step in the same cycle: that word or step is dropped, and no generator output is produced in that cycle.
- R3: With msb_first=0, an accepted word is processed for i = 0 to 31 as follows: fb = state[0] ^ data[i], then state = (state >> 1) ^ (fb ? poly : 0). All 32 steps complete within one clock.
- R4: With msb_first=1, an accepted word is processed for i = 31 down to 0 as follows: fb = state[31] ^ data[i], then state = (state << 1) ^ (fb ? poly : 0).
- R5: A word is accepted when crc_en=1, prng_en=0, din_valid=1 and state_wr=0. gf_done is high for exactly the cycle after an accepted word that carries din_last=1, and is low otherwise.
- R6: While prng_en=1, din_valid and crc_en have no effect: no word changes the state and gf_done stays low.
- R7: With prng_en=1 and ent_en=0, each clock applies 8 Galois steps with a zero data bit to the state. Bit k of rnd_data is the fb of step k. rnd_valid=1 and rnd_single=0.
- R8: With prng_en=1 and ent_en=1, each clock applies one Galois step whose data bit is ent_bit. rnd_data is {7'b0, fb}, with rnd_valid=1 and rnd_single=1.
- R9: With prng_en=0 and ent_en=1, rnd_data is {7'b0, ent_bit} as sampled at the edge, with rnd_valid=1 and rnd_single=1. The state is not touched, and a CRC word may be accepted in the same cycle.
- R10: With prng_en=0 and ent_en=0, rnd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crc_en | input | 1 | Select CRC processing of input words |
| prng_en | input | 1 | Run the state as a random generator |
| ent_en | input | 1 | Use the entropy bit |
| msb_first | input | 1 | Bit order and shift direction |
| poly_wr | input | 1 | Load polynomial |
| poly_wdata | input | 32 | Polynomial value |
| state_wr | input | 1 | Load state |
| state_wdata | input | 32 | State value |
| din_valid | input | 1 | Input word present |
| din_data | input | 32 | Input word |
| din_last | input | 1 | Word closes a batch |
| ent_bit | input | 1 | Entropy source bit |
| poly_q | output | 32 | Current polynomial |
| state_q | output | 32 | Current CRC result or generator state |
| rnd_data | output | 8 | Random output |
| rnd_valid | output | 1 | rnd_data holds new output |
| rnd_single | output | 1 | Only bit 0 of rnd_data is meaningful |
| gf_done | output | 1 | Batch-complete pulse |

## Verification
The generator is off, the entropy pass-through is on, and CRC words stream in, all at the same time. In that state a CRC word update and a raw entropy output fall in the same clock. The bench holds this condition for many cycles with random words and entropy bits. It judges each cycle by comparing state_q against a bench CRC model and rnd_data against the entropy bit driven before that edge. A second collision is a state load in the same cycle as a word that carries the last flag. It is provoked directly and judged by state_q taking the loaded value while gf_done stays low.

// File: rtl/gf_crc_prng_engine.sv
module gf_crc_prng_engine #(
  parameter int W = 32,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          crc_en,
  input  logic          prng_en,
  input  logic          ent_en,
  input  logic          msb_first,
  input  logic          poly_wr,
  input  logic [W-1:0]  poly_wdata,
  input  logic          state_wr,
  input  logic [W-1:0]  state_wdata,
  input  logic          din_valid,
  input  logic [W-1:0]  din_data,
  input  logic          din_last,
  input  logic          ent_bit,
  output logic [W-1:0]  poly_q,
  output logic [W-1:0]  state_q,
  output logic [OW-1:0] rnd_data,
  output logic          rnd_valid,
  output logic          rnd_single,
  output logic          gf_done
);

  function automatic logic [W:0] gf_step(logic [W-1:0] s, logic [W-1:0] p, logic d, logic msb);
    logic fb;
    logic [W-1:0] n;
    fb = (msb ? s[W-1] : s[0]) ^ d;
    n  = msb ? (s << 1) : (s >> 1);
    if (fb) n = n ^ p;
    return {fb, n};
  endfunction

  logic [W-1:0]  crc_next, byte_state, mix_state;
  logic [OW-1:0] byte_out;
  logic          mix_fb;
  logic [W:0]    t;

  always_comb begin
    crc_next = state_q;
    for (int i = 0; i < W; i++) begin
      t = gf_step(crc_next, poly_q, msb_first ? din_data[W-1-i] : din_data[i], msb_first);
      crc_next = t[W-1:0];
    end
    byte_state = state_q;
    byte_out   = '0;
    for (int k = 0; k < OW; k++) begin
      t = gf_step(byte_state, poly_q, 1'b0, msb_first);
      byte_state  = t[W-1:0];
      byte_out[k] = t[W];
    end
    t = gf_step(state_q, poly_q, ent_bit, msb_first);
    mix_state = t[W-1:0];
    mix_fb    = t[W];
  end

  logic crc_take, gen_step;
  assign crc_take = crc_en & ~prng_en & din_valid & ~state_wr;
  assign gen_step = prng_en & ~state_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      poly_q     <= '0;
      state_q    <= '0;
      rnd_data   <= '0;
      rnd_valid  <= 1'b0;
      rnd_single <= 1'b0;
      gf_done    <= 1'b0;
    end else begin
      if (poly_wr) poly_q <= poly_wdata;
      if (state_wr)                state_q <= state_wdata;
      else if (gen_step && ent_en) state_q <= mix_state;
      else if (gen_step)           state_q <= byte_state;
      else if (crc_take)           state_q <= crc_next;
      gf_done <= crc_take & din_last;
      if (gen_step) begin
        rnd_valid  <= 1'b1;
        rnd_single <= ent_en;
        rnd_data   <= ent_en ? {{(OW-1){1'b0}}, mix_fb} : byte_out;
      end else if (!prng_en && ent_en) begin
        rnd_valid  <= 1'b1;
        rnd_single <= 1'b1;
        rnd_data   <= {{(OW-1){1'b0}}, ent_bit};
      end else begin
        rnd_valid  <= 1'b0;
        rnd_single <= 1'b0;
        rnd_data   <= '0;
      end
    end
  end

  assert_done_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gf_done |-> $past(din_valid && din_last && crc_en));
  assert_prng_blocks_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prng_en |=> !gf_done);
  assert_raw_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!prng_en && ent_en) |=> (rnd_valid && rnd_single));
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!prng_en && !ent_en) |=> !rnd_valid);
  assert_single_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_valid && rnd_single) |-> (rnd_data[OW-1:1] == '0));
  assert_state_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!state_wr && !prng_en && !din_valid) |=> $stable(state_q));

endmodule

// File: tb/sim_gf_crc_prng_engine.sv
module sim_gf_crc_prng_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic crc_en = 0, prng_en = 0, ent_en = 0, msb_first = 0;
  logic poly_wr = 0, state_wr = 0, din_valid = 0, din_last = 0, ent_bit = 0;
  logic [31:0] poly_wdata = '0, state_wdata = '0, din_data = '0;
  logic [31:0] poly_q, state_q;
  logic [7:0]  rnd_data;
  logic        rnd_valid, rnd_single, gf_done;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] m_state, m_poly;

  always #5 clk = ~clk;

  gf_crc_prng_engine u0 (.*);

  function automatic logic [32:0] m_step(logic [31:0] s, logic [31:0] p, logic d, logic msb);
    logic fb;
    logic [31:0] n;
    if (msb) begin fb = s[31] ^ d; n = {s[30:0], 1'b0}; end
    else     begin fb = s[0] ^ d;  n = {1'b0, s[31:1]}; end
    n = n ^ (p & {32{fb}});
    return {fb, n};
  endfunction

  function automatic logic [31:0] m_crc(logic [31:0] s, logic [31:0] p, logic [31:0] d, logic msb);
    logic [32:0] r;
    for (int i = 0; i < 32; i++) begin
      r = m_step(s, p, msb ? d[31-i] : d[i], msb);
      s = r[31:0];
    end
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(logic [31:0] p, logic [31:0] s);
    poly_wr = 1; poly_wdata = p; state_wr = 1; state_wdata = s;
    tick();
    poly_wr = 0; state_wr = 0;
    m_poly = p; m_state = s;
  endtask

  initial begin
    int seed;
    logic [32:0] r;
    logic [7:0] eb;
    seed = $urandom(32'd771);
    @(negedge clk);
    tick(); tick();
    chk("R1 poly_q", poly_q, 0);
    chk("R1 state_q", state_q, 0);
    chk("R1 rnd", {rnd_valid, rnd_single, gf_done, rnd_data}, 0);
    rst_n = 1;

    load(32'hEDB88320, 32'hFFFFFFFF);
    chk("R2 poly_q", poly_q, 32'hEDB88320);
    chk("R2 state_q", state_q, 32'hFFFFFFFF);

    crc_en = 1;
    for (int ord = 0; ord < 2; ord++) begin
      msb_first = ord[0];
      if (ord == 1) load(32'h04C11DB7, 32'hFFFFFFFF);
      din_data = 32'h0; din_valid = 1; din_last = 0;
      for (int n = 0; n < 24; n++) begin
        if (n > 0) din_data = $urandom;
        din_last = (n % 6 == 5);
        tick();
        m_state = m_crc(m_state, m_poly, din_data, msb_first);
        chk(ord ? "R4 msb crc state" : "R3 lsb crc state", state_q, m_state);
        chk("R5 gf_done", {31'b0, gf_done}, {31'b0, din_last});
      end
      din_valid = 0; din_last = 0;
      tick();
      chk("R5 no done when idle", {31'b0, gf_done}, 0);
    end

    din_valid = 1; din_last = 1; din_data = 32'h12345678;
    state_wr = 1; state_wdata = 32'hCAFEF00D;
    tick();
    state_wr = 0; din_valid = 0; din_last = 0;
    m_state = 32'hCAFEF00D;
    chk("R2 write beats word", state_q, m_state);
    chk("R2 no done on dropped word", {31'b0, gf_done}, 0);

    ent_en = 1; din_valid = 1; msb_first = 0;
    for (int n = 0; n < 20; n++) begin
      din_data = $urandom; ent_bit = $urandom; din_last = (n == 19);
      tick();
      m_state = m_crc(m_state, m_poly, din_data, msb_first);
      chk("R9 crc beside entropy", state_q, m_state);
      chk("R9 raw entropy", {22'b0, rnd_valid, rnd_single, rnd_data}, {22'b0, 2'b11, 7'b0, ent_bit});
    end
    chk("R5 done beside entropy", {31'b0, gf_done}, 1);
    din_valid = 0; din_last = 0; ent_en = 0;
    tick();
    chk("R10 no output", {31'b0, rnd_valid}, 0);

    prng_en = 1; din_valid = 1; din_last = 1;
    for (int ord = 0; ord < 2; ord++) begin
      msb_first = ord[0];
      load(ord ? 32'h04C11DB7 : 32'hEDB88320, 32'h1ACE0001 + ord);
      for (int n = 0; n < 16; n++) begin
        din_data = $urandom;
        eb = '0;
        for (int k = 0; k < 8; k++) begin
          r = m_step(m_state, m_poly, 1'b0, msb_first);
          m_state = r[31:0]; eb[k] = r[32];
        end
        tick();
        chk("R7 byte state", state_q, m_state);
        chk("R7 byte out", {22'b0, rnd_valid, rnd_single, rnd_data}, {22'b0, 2'b10, eb});
        chk("R6 word ignored no done", {31'b0, gf_done}, 0);
      end
    end

    ent_en = 1;
    for (int n = 0; n < 24; n++) begin
      msb_first = n[0];
      ent_bit = $urandom;
      r = m_step(m_state, m_poly, ent_bit, msb_first);
      m_state = r[31:0];
      tick();
      chk("R8 mixed state", state_q, m_state);
      chk("R8 mixed bit", {22'b0, rnd_valid, rnd_single, rnd_data}, {22'b0, 2'b11, 7'b0, r[32]});
    end

    state_wr = 1; state_wdata = 32'h0BADBEEF;
    tick();
    state_wr = 0;
    m_state = 32'h0BADBEEF;
    chk("R2 write during prng", state_q, m_state);
    chk("R2 no output on write", {31'b0, rnd_valid}, 0);

    prng_en = 0; ent_en = 0; din_valid = 0; din_last = 0;
    tick();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule